// File: doc/BRIEF.md
# Amplifier Fault Protection Supervisor

This block guards a two-channel bridge-tied switching power stage. It watches a digitized die-temperature code, a digitized analog-supply code and one over-current flag per output half-bridge. While any of them reports trouble, it drives a single output-disable that the gate-driver logic uses to put every output transistor of both channels into high impedance.

Temperature and supply each have separate trip and release thresholds, so a reading near the limit does not chatter. Once protection is entered, the block does not leave it just because the fault goes away. A retry timer runs while protection is active, and each time it expires the block re-tests the inputs. Normal operation resumes only if every fault source is quiet in that cycle. A short over-current spike is captured and held until the next retry, so it cannot be missed.

After reset the block is protected and stays so until the first retry finds all inputs healthy. A two-bit status reports the class of fault behind the most recent entry into protection.

Top module: `amp_fault_supervisor`

## Requirements
- R1: While reset is held and after its release, `prot_active` and `out_disable` are 1 and `fault_cause` is 2'b00. The first retry comes RETRY_CYCLES clocks after reset is released, and if all inputs are healthy `prot_active` and `out_disable` drop on the next edge.
- R2: A `temp_code` of at least TEMP_TRIP (default 150) raises `out_disable` on the first clock edge that samples it and `prot_active` one edge later. The code TEMP_TRIP-1 does neither.
- R3: Once over-temperature is flagged, it stays flagged until `temp_code` is at most TEMP_CLEAR (default 130). A retry made while the code is between the two thresholds keeps protection on.
- R4: A `vsup_code` of at most UV_TRIP (default 60) raises `out_disable` on the first edge that samples it and `prot_active` one edge later. UV_TRIP+1 does neither.
- R5: Once undervoltage is flagged, it stays flagged until `vsup_code` is at least UV_CLEAR (default 70). A retry made at a lower code keeps protection on.
- R6: A 1 on any bit of `oc_flag`, even for a single clock, raises `out_disable` three edges later and `prot_active` four edges later. The flag passes through a two-stage synchronizer and is then held.
- R7: `retry_pulse` is one clock wide and occurs only while `prot_active` is 1. Pulses come every RETRY_CYCLES clocks, counted from the edge that entered protection.
- R8: At a retry the held over-current state is cleared. Protection is released on the next edge only if, in the pulse cycle, neither temperature nor supply is flagged and no synchronized over-current bit is 1. Otherwise protection continues to the next retry.
- R9: `fault_cause` is loaded only on entry into protection: 2'b01 over-current, 2'b10 over-temperature, 2'b11 undervoltage, with that priority when several are present. It holds through failed retries and after release.
- R10: `out_disable` is 1 whenever `prot_active` is 1.
- R11: `prot_active` falls only in the clock after a `retry_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| temp_code | input | TEMP_W | Digitized die temperature, larger is hotter |
| vsup_code | input | VOLT_W | Digitized analog supply voltage |
| oc_flag | input | N_BRIDGE | Asynchronous over-current flag, one per half-bridge |
| out_disable | output | 1 | Forces all output drivers to high impedance |
| prot_active | output | 1 | Supervisor is in the protected state |
| retry_pulse | output | 1 | One-clock strobe marking a restore attempt |
| fault_cause | output | 2 | Fault class behind the latest entry into protection |

## Verification
The bound checker checks several rules on every cycle: the disable covers the protected state, and retry strobes are single-cycle, occur only under protection and are spaced exactly by the retry period. It also checks that release happens only right after a strobe, that the cause is stable while protected, and that threshold crossings and over-current flags force the disable within their fixed latencies. Only the bench scenarios show the hysteresis: that a failed retry happens at a code between trip and release, and that release follows once the release code is reached. The bench scenarios also cover the exact boundary codes that must not trip, capture of a one-cycle over-current glitch, and the cause priority when faults coincide.

// File: rtl/afs_pkg.sv
// Package: shared types of the fault supervisor.
// Assumes: nothing beyond IEEE 1800-2017.
package afs_pkg;
    typedef enum logic [1:0] {
        CAUSE_NONE = 2'b00,
        CAUSE_OC   = 2'b01,
        CAUSE_TEMP = 2'b10,
        CAUSE_UV   = 2'b11
    } cause_e;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_PROT = 1'b1
    } sup_state_e;
endpackage

// File: rtl/afs_hyst.sv
// Module: two-threshold comparator with a held fault flag.
// TRIP_ABOVE=1 flags when code >= TRIP and clears when code <= CLEAR.
// TRIP_ABOVE=0 flags when code <= TRIP and clears when code >= CLEAR.
// Assumes: code is already synchronous to clk; the thresholds do not overlap.
module afs_hyst #(
    parameter int unsigned W          = 8,
    parameter int unsigned TRIP       = 150,
    parameter int unsigned CLEAR      = 130,
    parameter bit          TRIP_ABOVE = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] code,
    output logic         fault_q
);
    localparam logic [W-1:0] TRIP_C  = W'(TRIP);
    localparam logic [W-1:0] CLEAR_C = W'(CLEAR);

    logic set_c;
    logic clr_c;

    generate
        if (TRIP_ABOVE) begin : g_high
            assign set_c = (code >= TRIP_C);
            assign clr_c = (code <= CLEAR_C);
        end else begin : g_low
            assign set_c = (code <= TRIP_C);
            assign clr_c = (code >= CLEAR_C);
        end
    endgenerate

    // Hold the flag between the trip and the release thresholds.
    always_ff @(posedge clk) begin
        if (!rst_n)     fault_q <= 1'b0;
        else if (set_c) fault_q <= 1'b1;
        else if (clr_c) fault_q <= 1'b0;
    end
endmodule

// File: rtl/afs_oc_capture.sv
// Module: per-bridge over-current synchronizer and sticky capture.
// Each flag passes two flops, then sets a hold bit that only clear_i resets.
// A set in the same cycle as clear_i wins.
// Assumes: raw flags are asynchronous to clk and may last a single cycle.
module afs_oc_capture #(
    parameter int unsigned N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] oc_raw,
    input  logic         clear_i,
    output logic         oc_now,
    output logic         oc_held
);
    logic [N-1:0] s1_q;
    logic [N-1:0] s2_q;
    logic [N-1:0] hold_q;

    generate
        for (genvar b = 0; b < N; b++) begin : g_bridge
            // Two-stage synchronizer for this bridge.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    s1_q[b] <= 1'b0;
                    s2_q[b] <= 1'b0;
                end else begin
                    s1_q[b] <= oc_raw[b];
                    s2_q[b] <= s1_q[b];
                end
            end

            // Sticky capture, cleared by a retry unless set again.
            always_ff @(posedge clk) begin
                if (!rst_n)          hold_q[b] <= 1'b0;
                else if (s2_q[b])    hold_q[b] <= 1'b1;
                else if (clear_i)    hold_q[b] <= 1'b0;
            end
        end
    endgenerate

    assign oc_now  = |s2_q;
    assign oc_held = |hold_q;
endmodule

// File: rtl/afs_retry_timer.sv
// Module: free-running retry period counter, enabled while protected.
// tick is high for one cycle every CYCLES cycles of run; the count restarts
// from zero whenever run is low.
// Assumes: CYCLES >= 2.
module afs_retry_timer #(
    parameter int unsigned CYCLES = 125_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int unsigned    CW   = (CYCLES > 2) ? $clog2(CYCLES) : 1;
    localparam logic [CW-1:0]  LAST = CW'(CYCLES - 1);

    logic [CW-1:0] cnt_q;

    // Count cycles spent protected, wrapping at the period end.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (!run)          cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
    end

    assign tick = run && (cnt_q == LAST);
endmodule

// File: rtl/amp_fault_supervisor.sv
// Module: fault protection supervisor for a two-channel bridged amplifier.
// Combines held temperature, undervoltage and over-current flags into one
// output disable, and restores operation only at periodic retry points.
// Assumes: temp and supply codes are synchronous; oc_flag is asynchronous.
module amp_fault_supervisor
    import afs_pkg::*;
#(
    parameter int unsigned TEMP_W       = 8,
    parameter int unsigned VOLT_W       = 8,
    parameter int unsigned N_BRIDGE     = 4,
    parameter int unsigned TEMP_TRIP    = 150,
    parameter int unsigned TEMP_CLEAR   = 130,
    parameter int unsigned UV_TRIP      = 60,
    parameter int unsigned UV_CLEAR     = 70,
    parameter int unsigned RETRY_CYCLES = 125_000_000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [TEMP_W-1:0]   temp_code,
    input  logic [VOLT_W-1:0]   vsup_code,
    input  logic [N_BRIDGE-1:0] oc_flag,
    output logic                out_disable,
    output logic                prot_active,
    output logic                retry_pulse,
    output logic [1:0]          fault_cause
);
    logic       hot_q;
    logic       low_q;
    logic       oc_now;
    logic       oc_held;
    logic       tick;
    logic       fault_any;
    logic       healthy_now;
    sup_state_e state_q;
    cause_e     cause_q;

    afs_hyst #(
        .W(TEMP_W), .TRIP(TEMP_TRIP), .CLEAR(TEMP_CLEAR), .TRIP_ABOVE(1'b1)
    ) u_temp (
        .clk(clk), .rst_n(rst_n), .code(temp_code), .fault_q(hot_q)
    );

    afs_hyst #(
        .W(VOLT_W), .TRIP(UV_TRIP), .CLEAR(UV_CLEAR), .TRIP_ABOVE(1'b0)
    ) u_uv (
        .clk(clk), .rst_n(rst_n), .code(vsup_code), .fault_q(low_q)
    );

    afs_oc_capture #(
        .N(N_BRIDGE)
    ) u_oc (
        .clk(clk), .rst_n(rst_n), .oc_raw(oc_flag), .clear_i(tick),
        .oc_now(oc_now), .oc_held(oc_held)
    );

    afs_retry_timer #(
        .CYCLES(RETRY_CYCLES)
    ) u_timer (
        .clk(clk), .rst_n(rst_n), .run(state_q == ST_PROT), .tick(tick)
    );

    assign fault_any   = hot_q | low_q | oc_held;
    assign healthy_now = !hot_q && !low_q && !oc_now;

    // Enter protection on any fault; leave only at a healthy retry point.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_PROT;
            cause_q <= CAUSE_NONE;
        end else begin
            case (state_q)
                ST_RUN: begin
                    if (fault_any) begin
                        state_q <= ST_PROT;
                        if (oc_held)    cause_q <= CAUSE_OC;
                        else if (hot_q) cause_q <= CAUSE_TEMP;
                        else            cause_q <= CAUSE_UV;
                    end
                end
                default: begin
                    if (tick && healthy_now) state_q <= ST_RUN;
                end
            endcase
        end
    end

    assign prot_active = (state_q == ST_PROT);
    assign out_disable = prot_active | fault_any;
    assign retry_pulse = tick;
    assign fault_cause = cause_q;
endmodule

// File: rtl/afs_checker.sv
// Module: assertion checker bound to amp_fault_supervisor.
// Observes the top-level ports only; keeps its own retry spacing counter.
// Assumes: RETRY_CYCLES >= 2.
module afs_checker #(
    parameter int unsigned TEMP_W       = 8,
    parameter int unsigned VOLT_W       = 8,
    parameter int unsigned N_BRIDGE     = 4,
    parameter int unsigned TEMP_TRIP    = 150,
    parameter int unsigned UV_TRIP      = 60,
    parameter int unsigned RETRY_CYCLES = 125_000_000
) (
    input logic                clk,
    input logic                rst_n,
    input logic [TEMP_W-1:0]   temp_code,
    input logic [VOLT_W-1:0]   vsup_code,
    input logic [N_BRIDGE-1:0] oc_flag,
    input logic                out_disable,
    input logic                prot_active,
    input logic                retry_pulse,
    input logic [1:0]          fault_cause
);
    localparam int unsigned       GW     = (RETRY_CYCLES > 2) ? $clog2(RETRY_CYCLES) : 1;
    localparam logic [GW-1:0]     GAP    = GW'(RETRY_CYCLES - 1);
    localparam logic [TEMP_W-1:0] TTRIP  = TEMP_W'(TEMP_TRIP);
    localparam logic [VOLT_W-1:0] VTRIP  = VOLT_W'(UV_TRIP);

    logic [GW-1:0] gap_q;

    // Cycles since protection entry or the last retry strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)           gap_q <= '0;
        else if (!prot_active) gap_q <= '0;
        else if (retry_pulse)  gap_q <= '0;
        else                   gap_q <= gap_q + 1'b1;
    end

    AST_DISABLE_COVERS_PROT: assert property (@(posedge clk) disable iff (!rst_n)
        prot_active |-> out_disable); // R10
    AST_RETRY_ONLY_PROTECTED: assert property (@(posedge clk) disable iff (!rst_n)
        retry_pulse |-> prot_active); // R7
    AST_RETRY_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        retry_pulse |=> !retry_pulse); // R7
    AST_RETRY_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        retry_pulse |-> (gap_q == GAP)); // R7
    AST_RELEASE_AT_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prot_active) |-> $past(retry_pulse)); // R11
    AST_CAUSE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_active && $past(prot_active)) |-> $stable(fault_cause)); // R9
    AST_TEMP_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
        (temp_code >= TTRIP) |=> out_disable); // R2
    AST_UV_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
        (vsup_code <= VTRIP) |=> out_disable); // R4
    AST_OC_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
        (|oc_flag) |-> ##3 out_disable); // R6
endmodule

bind amp_fault_supervisor afs_checker #(
    .TEMP_W(TEMP_W), .VOLT_W(VOLT_W), .N_BRIDGE(N_BRIDGE),
    .TEMP_TRIP(TEMP_TRIP), .UV_TRIP(UV_TRIP), .RETRY_CYCLES(RETRY_CYCLES)
) chk_i (
    .clk(clk), .rst_n(rst_n), .temp_code(temp_code), .vsup_code(vsup_code),
    .oc_flag(oc_flag), .out_disable(out_disable), .prot_active(prot_active),
    .retry_pulse(retry_pulse), .fault_cause(fault_cause)
);

// File: tb/amp_fault_supervisor_tb_top.sv
// Bench: scoreboard for amp_fault_supervisor. The driver schedules expected
// output values for absolute cycle numbers; the monitor compares them just
// after each rising edge. Retry period shortened to 20 clocks.
module amp_fault_supervisor_tb_top;
    localparam int RETRY = 20;
    localparam int W_DIS = 0, W_PROT = 1, W_RETRY = 2, W_CAUSE = 3;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] temp_code;
    logic [7:0] vsup_code;
    logic [3:0] oc_flag;
    logic       out_disable;
    logic       prot_active;
    logic       retry_pulse;
    logic [1:0] fault_cause;

    typedef struct {
        int    due;
        int    what;
        int    val;
        string req;
    } exp_t;

    exp_t exp_q[$];
    int   cyc   = 0;
    int   n_vec = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    always #4 clk = ~clk;

    amp_fault_supervisor #(.RETRY_CYCLES(RETRY)) dut_i (
        .clk(clk), .rst_n(rst_n), .temp_code(temp_code), .vsup_code(vsup_code),
        .oc_flag(oc_flag), .out_disable(out_disable), .prot_active(prot_active),
        .retry_pulse(retry_pulse), .fault_cause(fault_cause)
    );

    task automatic expa(int due, int what, int val, string req);
        exp_t e;
        e.due = due; e.what = what; e.val = val; e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: compare every expectation due at this edge.
    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            #2;
            for (int i = 0; i < exp_q.size(); ) begin
                if (exp_q[i].due == cyc) begin
                    int act;
                    case (exp_q[i].what)
                        W_DIS:   act = int'(out_disable);
                        W_PROT:  act = int'(prot_active);
                        W_RETRY: act = int'(retry_pulse);
                        default: act = int'(fault_cause);
                    endcase
                    n_vec++;
                    if (act != exp_q[i].val) begin
                        n_bad++;
                        $display("FAIL %s cycle %0d output %0d: actual %0d expected %0d",
                                 exp_q[i].req, cyc, exp_q[i].what, act, exp_q[i].val);
                    end
                    exp_q.delete(i);
                end else begin
                    i++;
                end
            end
        end
    end

    // Watchdog: a hung run is one failed check.
    initial begin
        #(8 * 20000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    // Driver: stimulus and expected values per requirement.
    initial begin
        int b;
        rst_n = 1'b0; temp_code = 8'd25; vsup_code = 8'd100; oc_flag = 4'b0;
        step(4);
        // R1: reset state and first retry release
        rst_n = 1'b1; b = cyc;
        expa(b+1,  W_PROT, 1, "R1"); expa(b+1, W_DIS, 1, "R1"); expa(b+1, W_CAUSE, 0, "R1");
        expa(b+18, W_RETRY, 0, "R7"); expa(b+19, W_RETRY, 1, "R7");
        expa(b+20, W_RETRY, 0, "R7"); expa(b+20, W_PROT, 0, "R1"); expa(b+20, W_DIS, 0, "R1");
        step(22);

        // R2: one below trip has no effect
        b = cyc; temp_code = 8'd149;
        expa(b+1, W_DIS, 0, "R2"); expa(b+2, W_PROT, 0, "R2"); expa(b+1, W_RETRY, 0, "R7");
        step(3);

        // R2/R3: trip at 150, hold at 140, release at 130
        b = cyc; temp_code = 8'd150;
        expa(b+1, W_DIS, 1, "R2"); expa(b+1, W_PROT, 0, "R2");
        expa(b+2, W_PROT, 1, "R2"); expa(b+2, W_CAUSE, 2, "R9");
        step(1); temp_code = 8'd140;
        expa(b+21, W_RETRY, 1, "R7"); expa(b+22, W_PROT, 1, "R3");
        step(24); temp_code = 8'd130;
        expa(b+41, W_RETRY, 1, "R7"); expa(b+41, W_CAUSE, 2, "R9");
        expa(b+42, W_PROT, 0, "R3"); expa(b+42, W_DIS, 0, "R3");
        step(18); temp_code = 8'd25;

        // R4: one above undervoltage trip has no effect
        b = cyc; vsup_code = 8'd61;
        expa(b+1, W_DIS, 0, "R4"); expa(b+2, W_PROT, 0, "R4");
        step(3);

        // R4/R5: trip at 60, hold at 65 and 69, release at 70
        b = cyc; vsup_code = 8'd60;
        expa(b+1, W_DIS, 1, "R4"); expa(b+2, W_PROT, 1, "R4"); expa(b+2, W_CAUSE, 3, "R9");
        step(1); vsup_code = 8'd65;
        expa(b+22, W_PROT, 1, "R5");
        step(24); vsup_code = 8'd69;
        expa(b+42, W_PROT, 1, "R5");
        step(20); vsup_code = 8'd70;
        expa(b+61, W_RETRY, 1, "R7"); expa(b+62, W_PROT, 0, "R5");
        step(19); vsup_code = 8'd100;

        // R6/R8: one-cycle over-current glitch is captured, then released
        b = cyc; oc_flag = 4'b0100;
        step(1); oc_flag = 4'b0000;
        expa(b+2, W_DIS, 0, "R6"); expa(b+3, W_DIS, 1, "R6"); expa(b+3, W_PROT, 0, "R6");
        expa(b+4, W_PROT, 1, "R6"); expa(b+4, W_CAUSE, 1, "R9");
        expa(b+23, W_RETRY, 1, "R8"); expa(b+24, W_PROT, 0, "R8"); expa(b+24, W_DIS, 0, "R8");
        step(25);

        // R8: persistent over-current fails a retry, releases after removal
        b = cyc; oc_flag = 4'b0001;
        expa(b+4, W_PROT, 1, "R6"); expa(b+23, W_RETRY, 1, "R8"); expa(b+24, W_PROT, 1, "R8");
        step(25); oc_flag = 4'b0000;
        expa(b+43, W_RETRY, 1, "R8"); expa(b+44, W_PROT, 0, "R8");
        step(21);

        // R9: over-current outranks over-temperature; cause kept after release
        b = cyc; oc_flag = 4'b1000;
        step(1); oc_flag = 4'b0000;
        step(1); temp_code = 8'd150;
        expa(b+4, W_PROT, 1, "R9"); expa(b+4, W_CAUSE, 1, "R9");
        step(3); temp_code = 8'd25;
        expa(b+24, W_PROT, 0, "R8"); expa(b+24, W_CAUSE, 1, "R9");
        step(21);

        // R9: over-temperature outranks undervoltage
        b = cyc; temp_code = 8'd150; vsup_code = 8'd50;
        expa(b+2, W_PROT, 1, "R9"); expa(b+2, W_CAUSE, 2, "R9");
        step(3); temp_code = 8'd25; vsup_code = 8'd100;
        expa(b+22, W_PROT, 0, "R8");
        step(21);

        step(2);
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule